// File: doc/BRIEF.md
# Serial SRAM Download Loader

This block lets a host with only a handful of control lines fill and inspect a 4K x 16 static RAM. The host presents one serial data line and five strobe lines. Each rising edge on the address strobe shifts one bit into a 12-bit address register. Each rising edge on the write-data strobe shifts one bit into a 16-bit word register. A rising edge on the write strobe then runs one RAM write cycle. The data lines are driven for a setup cycle, held through the write-enable pulse, and held again for one cycle after it.

To verify a location, the host shifts in the address and raises the capture strobe. The loader releases the data lines and asserts output enable for a fixed number of cycles. It then latches the RAM word in parallel into a read-back register. The host clocks that register out one bit per read strobe on a serial output.

All strobes are treated as asynchronous. They pass through a synchronizer, and only their rising edges act. Two status outputs report that the loader is idle and that the last bus cycle was a completed write.

Top module: `sram_serial_loader`

## Requirements
- R1: After reset, `ready` is 1, `wrote` is 0, `host_sdo` is 0, `sram_addr` is 0, and both `sram_we_n` and `sram_oe_n` are 1.
- R2: Twelve rising edges of `stb_addr` shift `host_sdi` into the address register least significant bit first. The first bit shifted ends up at bit 0. `sram_addr` shows the register directly.
- R3: Sixteen rising edges of `stb_wdata` assemble the write word least significant bit first. A rising edge of `stb_write` then produces exactly one low pulse on `sram_we_n`, WE_CYCLES clocks long (default 2), which stores that word at `sram_addr`.
- R4: `sram_we_n` and `sram_oe_n` are never low together. While `sram_we_n` is low, the loader drives `sram_dq` with the write word.
- R5: A rising edge of `stb_capture` holds `sram_oe_n` low for RD_CYCLES clocks (default 2) with the data lines released, then latches `sram_dq`. `host_sdo` then shows bit 0 of that word, and each rising edge of `stb_rdata` advances it to the next higher bit.
- R6: `ready` is 0 throughout a write or capture cycle. `wrote` becomes 1 when a write cycle ends and returns to 0 on the next rising edge of any strobe.
- R7: Strobe edges that arrive while `ready` is 0 are ignored. The address register, and so `sram_addr`, is unchanged by them.
- R8: A strobe held high for many clocks counts as a single edge, so it shifts exactly one bit.
- R9: The read-back register fills with zeros from the top. After 16 read strobes following a capture, `host_sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sdi | input | 1 | Serial data from host |
| stb_addr | input | 1 | Address shift strobe |
| stb_wdata | input | 1 | Write-word shift strobe |
| stb_rdata | input | 1 | Read-back shift strobe |
| stb_capture | input | 1 | Capture strobe: read RAM into the read-back register |
| stb_write | input | 1 | Write strobe: start a RAM write cycle |
| host_sdo | output | 1 | Serial read-back bit to host |
| ready | output | 1 | High when no bus cycle is in progress |
| wrote | output | 1 | High after a completed write until the next strobe |
| sram_addr | output | 12 | RAM address |
| sram_dq | inout | 16 | RAM data lines |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |

## Verification
The bench writes boundary words (all ones, single top bit, single low bit, a mixed pattern) to the lowest address, the highest address and the middle boundary. It reads them back from a RAM model that is preloaded with other data. A shift in the wrong bit order, or a capture taken before output enable, shows up as a mismatched word. A per-cycle monitor counts write-enable and output-enable low cycles and flags any overlap. It also flags write-enable low while the data lines do not carry the word, which catches a pulse of the wrong length or data released too early.

A strobe edge injected during a write cycle must leave the address untouched; a loader that did not gate its shifters would move it. A strobe held high for twenty clocks must shift once; a level-sensitive loader would shift many times.

// File: rtl/sload_pkg.sv
package sload_pkg;

   typedef enum logic [2:0] {
      BUS_IDLE,
      BUS_SETUP,
      BUS_WRITE,
      BUS_HOLD,
      BUS_READ
   } bus_state_t;

   localparam int STB_ADDR    = 0;
   localparam int STB_WDATA   = 1;
   localparam int STB_RDATA   = 2;
   localparam int STB_CAPTURE = 3;
   localparam int STB_WRITE   = 4;
   localparam int STB_COUNT   = 5;

endpackage

// File: rtl/sload_strobe_sync.sv
module sload_strobe_sync #(
   parameter int LINES  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lines_i,
   input  logic             sdi_i,
   output logic [LINES-1:0] rise_o,
   output logic             sdi_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sload_strobe_sync: STAGES must be at least 2");
      end
      if (LINES < 1) begin : g_bad_lines
         $error("sload_strobe_sync: LINES must be at least 1");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < LINES; i++) begin : g_line
         logic [STAGES-1:0] chain;
         logic              last;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain <= '0;
               last  <= 1'b0;
            end else begin
               chain <= {chain[STAGES-2:0], lines_i[i]};
               last  <= chain[STAGES-1];
            end
         end
         assign rise_o[i] = chain[STAGES-1] & ~last;

         // R8: an edge pulse never lasts two cycles
         p_single_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[i] |=> !rise_o[i]);
      end
   endgenerate

   // serial data takes the same path length so it lines up with the edges
   logic [STAGES-1:0] sdi_chain;
   always_ff @(posedge clk) begin
      if (!rst_n) sdi_chain <= '0;
      else        sdi_chain <= {sdi_chain[STAGES-2:0], sdi_i};
   end
   assign sdi_o = sdi_chain[STAGES-1];

endmodule

// File: rtl/sload_shifter.sv
module sload_shifter #(
   parameter int W         = 16,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_i,
   input  logic         load_i,
   input  logic         sdi_i,
   input  logic [W-1:0] par_i,
   output logic [W-1:0] par_o
);

   generate
      if (W < 2) begin : g_bad_width
         $error("sload_shifter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] word_q;
   logic [W-1:0] shifted;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign shifted = {sdi_i, word_q[W-1:1]};
      end else begin : g_msb
         assign shifted = {word_q[W-2:0], sdi_i};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       word_q <= '0;
      else if (load_i)  word_q <= par_i;
      else if (shift_i) word_q <= shifted;
   end

   assign par_o = word_q;

   // R5: the register only moves on a shift or a load
   p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_i && !load_i) |=> $stable(par_o));

endmodule

// File: rtl/sload_bus_seq.sv
module sload_bus_seq
   import sload_pkg::*;
#(
   parameter int WE_CYCLES = 2,
   parameter int RD_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_req_i,
   input  logic rd_req_i,
   input  logic any_stb_i,
   output logic ready_o,
   output logic drive_en_o,
   output logic we_n_o,
   output logic oe_n_o,
   output logic capture_o,
   output logic wrote_o
);

   generate
      if (WE_CYCLES < 1 || RD_CYCLES < 1) begin : g_bad_cycles
         $error("sload_bus_seq: pulse lengths must be at least 1");
      end
   endgenerate

   localparam int MAXC = (WE_CYCLES > RD_CYCLES) ? WE_CYCLES : RD_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] WE_LAST = CW'(WE_CYCLES - 1);
   localparam logic [CW-1:0] RD_LAST = CW'(RD_CYCLES - 1);

   bus_state_t      st_q;
   logic [CW-1:0]   cnt_q;
   logic            wrote_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= BUS_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            BUS_IDLE: begin
               cnt_q <= '0;
               if (wr_req_i)      st_q <= BUS_SETUP;
               else if (rd_req_i) st_q <= BUS_READ;
            end
            BUS_SETUP: st_q <= BUS_WRITE;
            BUS_WRITE: begin
               if (cnt_q == WE_LAST) begin
                  cnt_q <= '0;
                  st_q  <= BUS_HOLD;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            BUS_HOLD: st_q <= BUS_IDLE;
            BUS_READ: begin
               if (cnt_q == RD_LAST) begin
                  cnt_q <= '0;
                  st_q  <= BUS_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st_q <= BUS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                wrote_q <= 1'b0;
      else if (st_q == BUS_HOLD) wrote_q <= 1'b1;
      else if (any_stb_i)        wrote_q <= 1'b0;
   end

   assign ready_o    = (st_q == BUS_IDLE);
   assign drive_en_o = (st_q == BUS_SETUP) || (st_q == BUS_WRITE) || (st_q == BUS_HOLD);
   assign we_n_o     = (st_q != BUS_WRITE);
   assign oe_n_o     = (st_q != BUS_READ);
   assign capture_o  = (st_q == BUS_READ) && (cnt_q == RD_LAST);
   assign wrote_o    = wrote_q;

   // ---- checks ----
   logic [CW:0] we_low_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)       we_low_cnt <= '0;
      else if (!we_n_o) we_low_cnt <= we_low_cnt + 1'b1;
      else              we_low_cnt <= '0;
   end

   p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n_o && !oe_n_o));

   p_we_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n_o |-> drive_en_o);

   p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n_o) |-> (we_low_cnt == (CW+1)'(WE_CYCLES)));

   p_wrote_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wrote_o |-> ready_o);

   p_capture_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      capture_o |-> (!oe_n_o && !drive_en_o));

endmodule

// File: rtl/sram_serial_loader.sv
module sram_serial_loader
   import sload_pkg::*;
#(
   parameter int AW          = 12,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter int WE_CYCLES   = 2,
   parameter int RD_CYCLES   = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_sdi,
   input  logic          stb_addr,
   input  logic          stb_wdata,
   input  logic          stb_rdata,
   input  logic          stb_capture,
   input  logic          stb_write,
   output logic          host_sdo,
   output logic          ready,
   output logic          wrote,
   output logic [AW-1:0] sram_addr,
   inout  wire  [DW-1:0] sram_dq,
   output logic          sram_oe_n,
   output logic          sram_we_n
);

   generate
      if (AW < 2 || DW < 2) begin : g_bad_dims
         $error("sram_serial_loader: AW and DW must be at least 2");
      end
   endgenerate

   logic [STB_COUNT-1:0] stb_raw;
   logic [STB_COUNT-1:0] stb_rise;
   logic                 sdi_sync;
   logic                 drive_en;
   logic                 capture;
   logic [DW-1:0]        wr_word;
   logic [DW-1:0]        rd_word;

   assign stb_raw[STB_ADDR]    = stb_addr;
   assign stb_raw[STB_WDATA]   = stb_wdata;
   assign stb_raw[STB_RDATA]   = stb_rdata;
   assign stb_raw[STB_CAPTURE] = stb_capture;
   assign stb_raw[STB_WRITE]   = stb_write;

   sload_strobe_sync #(.LINES(STB_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines_i (stb_raw),
      .sdi_i   (host_sdi),
      .rise_o  (stb_rise),
      .sdi_o   (sdi_sync)
   );

   sload_shifter #(.W(AW), .LSB_FIRST(LSB_FIRST)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (stb_rise[STB_ADDR] & ready),
      .load_i  (1'b0),
      .sdi_i   (sdi_sync),
      .par_i   ('0),
      .par_o   (sram_addr)
   );

   sload_shifter #(.W(DW), .LSB_FIRST(LSB_FIRST)) u_wdata (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (stb_rise[STB_WDATA] & ready),
      .load_i  (1'b0),
      .sdi_i   (sdi_sync),
      .par_i   ('0),
      .par_o   (wr_word)
   );

   sload_shifter #(.W(DW), .LSB_FIRST(LSB_FIRST)) u_rdata (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (stb_rise[STB_RDATA] & ready),
      .load_i  (capture),
      .sdi_i   (1'b0),
      .par_i   (sram_dq),
      .par_o   (rd_word)
   );

   sload_bus_seq #(.WE_CYCLES(WE_CYCLES), .RD_CYCLES(RD_CYCLES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_req_i   (stb_rise[STB_WRITE]),
      .rd_req_i   (stb_rise[STB_CAPTURE]),
      .any_stb_i  (|stb_rise),
      .ready_o    (ready),
      .drive_en_o (drive_en),
      .we_n_o     (sram_we_n),
      .oe_n_o     (sram_oe_n),
      .capture_o  (capture),
      .wrote_o    (wrote)
   );

   generate
      if (LSB_FIRST) begin : g_out_lsb
         assign host_sdo = rd_word[0];
      end else begin : g_out_msb
         assign host_sdo = rd_word[DW-1];
      end
   endgenerate

   assign sram_dq = drive_en ? wr_word : {DW{1'bz}};

   // R7: the address does not move while a bus cycle is running
   p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && $past(!ready)) |-> $stable(sram_addr));

   // R1: control lines are inactive when idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (sram_we_n && sram_oe_n));

endmodule

// File: tb/tb_sram_serial_loader.sv
module tb_sram_serial_loader;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 12;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_sdi = 1'b0;
   logic          stb_addr = 1'b0, stb_wdata = 1'b0, stb_rdata = 1'b0;
   logic          stb_capture = 1'b0, stb_write = 1'b0;
   logic          host_sdo, ready, wrote, sram_oe_n, sram_we_n;
   logic [AW-1:0] sram_addr;
   wire  [DW-1:0] sram_dq;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_serial_loader dut (
      .clk(clk), .rst_n(rst_n), .host_sdi(host_sdi),
      .stb_addr(stb_addr), .stb_wdata(stb_wdata), .stb_rdata(stb_rdata),
      .stb_capture(stb_capture), .stb_write(stb_write),
      .host_sdo(host_sdo), .ready(ready), .wrote(wrote),
      .sram_addr(sram_addr), .sram_dq(sram_dq),
      .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
   );

   // ---- RAM model ----
   logic [DW-1:0] mem [0:(1<<AW)-1];
   logic          prev_we = 1'b1;
   assign sram_dq = (!sram_oe_n && sram_we_n) ? mem[sram_addr] : {DW{1'bz}};

   initial begin
      for (int i = 0; i < (1<<AW); i++) mem[i] = 16'h5A00 ^ i[15:0];
   end

   // ---- bus monitor ----
   int            n_we_low = 0, n_oe_low = 0, n_overlap = 0, n_bad_drive = 0;
   logic [DW-1:0] exp_wdata = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!sram_we_n) n_we_low++;
         if (!sram_oe_n) n_oe_low++;
         if (!sram_we_n && !sram_oe_n) n_overlap++;
         if (!sram_we_n && sram_dq !== exp_wdata) n_bad_drive++;
         if (!prev_we && sram_we_n) mem[sram_addr] = sram_dq;
         prev_we = sram_we_n;
      end
   end

   // ---- scoreboard ----
   int            n_chk = 0, n_fail = 0;
   logic [27:0]   exp_q [$];
   bit            finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse(input int which, input logic bitv);
      @(negedge clk);
      host_sdi = bitv;
      case (which)
         0: stb_addr = 1'b1;
         1: stb_wdata = 1'b1;
         2: stb_rdata = 1'b1;
         3: stb_capture = 1'b1;
         default: stb_write = 1'b1;
      endcase
      repeat (3) @(negedge clk);
      stb_addr = 1'b0; stb_wdata = 1'b0; stb_rdata = 1'b0;
      stb_capture = 1'b0; stb_write = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_ready();
      for (int k = 0; k < 50 && !ready; k++) @(negedge clk);
   endtask

   task automatic load_addr(input logic [AW-1:0] a);
      for (int b = 0; b < AW; b++) pulse(0, a[b]);
      chk("R2 address assembled LSB first", 32'(sram_addr), 32'(a));
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      load_addr(a);
      for (int b = 0; b < DW; b++) pulse(1, d[b]);
      exp_wdata = d;
      pulse(4, 1'b0);
      wait_ready();
      @(negedge clk);
      chk("R6 wrote after write cycle", 32'(wrote), 32'd1);
      chk("R3 RAM holds written word", 32'(mem[a]), 32'(d));
      exp_q.push_back({a, d});
   endtask

   task automatic do_readback();
      logic [27:0]   item;
      logic [DW-1:0] got;
      item = exp_q.pop_front();
      load_addr(item[27:16]);
      chk("R6 wrote cleared by strobe", 32'(wrote), 32'd0);
      pulse(3, 1'b0);
      wait_ready();
      @(negedge clk);
      for (int b = 0; b < DW; b++) begin
         got[b] = host_sdo;
         pulse(2, 1'b0);
      end
      chk("R5 read-back word", 32'(got), 32'(item[15:0]));
      chk("R9 zeros after full read-back", 32'(host_sdo), 32'd0);
   endtask

   initial begin
      logic [AW-1:0] held;
      repeat (3) @(negedge clk);
      chk("R1 ready", 32'(ready), 32'd1);
      chk("R1 wrote", 32'(wrote), 32'd0);
      chk("R1 sdo", 32'(host_sdo), 32'd0);
      chk("R1 addr", 32'(sram_addr), 32'd0);
      chk("R1 we_n/oe_n", {30'd0, sram_we_n, sram_oe_n}, 32'd3);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_write(12'h000, 16'hA5C3);
      do_write(12'hFFF, 16'hFFFF);
      do_write(12'h800, 16'h0001);
      do_write(12'h123, 16'h8000);
      for (int r = 0; r < 4; r++) do_readback();
      chk("R5 output-enable low cycles", 32'(n_oe_low), 32'd8);

      // R7: address strobe injected during a write cycle
      held = sram_addr;
      @(negedge clk);
      host_sdi = 1'b1;
      stb_write = 1'b1;
      repeat (2) @(negedge clk);
      stb_addr = 1'b1;
      repeat (3) @(negedge clk);
      stb_write = 1'b0; stb_addr = 1'b0;
      wait_ready();
      repeat (4) @(negedge clk);
      chk("R7 address unchanged by strobe during write", 32'(sram_addr), 32'(held));

      // R8: strobe held high shifts once
      @(negedge clk);
      host_sdi = 1'b1;
      stb_addr = 1'b1;
      repeat (20) @(negedge clk);
      stb_addr = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8 held strobe shifts one bit", 32'(sram_addr), 32'({1'b1, held[AW-1:1]}));

      chk("R3 write-enable low cycles", 32'(n_we_low), 32'd10);
      chk("R4 no WE/OE overlap", 32'(n_overlap), 32'd0);
      chk("R4 data driven during WE", 32'(n_bad_drive), 32'd0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule